// File: doc/BRIEF.md
# Multi-Block Transfer Sequencer

The sequencer moves a run of 128-bit blocks from memory, through a cipher engine, and back to memory. A one-cycle start strobe captures a source address, a destination address and a 15-bit size field. The size field holds the total length in bytes minus one, so only its upper bits set the number of blocks. For each block the sequencer reads four 32-bit words from the source pointer and presents the assembled block to the engine. It waits for the engine's result and then writes four 32-bit words to the destination pointer. Both pointers move forward by 16 bytes for each block.

The memory side uses a simple level request. The sequencer holds a request with its address, direction and write data until the memory answers with an acknowledge or an error. A completion pulse follows the last write of the last block. An error answer on any access stops the transfer at once and raises an error pulse instead of the completion pulse. Software sees these pulses on status flags that live outside this block.

Top module: `blkdma_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `mem_req`, `eng_start`, `xfer_done` and `xfer_err` are all 0.
- R2: A transfer handles exactly `size_field[14:4] + 1` blocks. Bits [3:0] of the size field have no effect, so 0x0000 and 0x000F each give one block, 0x0015 gives two, and 0x7FFF gives 2048.
- R3: A strobe on `start` while idle begins a transfer with reads (`mem_we` = 0). Block b (counted from 0) reads the addresses `rd_base + 16*b + 4*k` for k = 0..3, in that order.
- R4: The word read at offset k = 0 forms bits [127:96] of `eng_din`. The following words fill the lower lanes in address order, so k = 3 forms bits [31:0].
- R5: After the fourth read of a block is acknowledged, `eng_start` is high for exactly one cycle. No memory request is made until `eng_done` returns the result on `eng_result`.
- R6: Block b writes the addresses `wr_base + 16*b + 4*k` for k = 0..3, in that order, with `mem_we` = 1. Word k carries `eng_result` bits [127-32k : 96-32k] of that block.
- R7: While `mem_req` is high and neither `mem_ack` nor `mem_err` is high, the next cycle keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R8: `xfer_done` is a one-cycle pulse in the first cycle after the acknowledge of the last write of the last block. In that same cycle `busy` is already 0. Each completed transfer gives exactly one pulse.
- R9: `mem_err` on any access ends the transfer. The next cycle shows a one-cycle `xfer_err` pulse with `busy` at 0, no further access is requested, and `xfer_done` does not pulse. An error takes precedence over an acknowledge that arrives in the same cycle.
- R10: A `start` strobe while `busy` is high is ignored. The running transfer keeps its addresses and block count, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, taken only when idle |
| rd_base | input | 32 | Source start address |
| wr_base | input | 32 | Destination start address |
| size_field | input | 15 | Total byte length minus one |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access request, held until answered |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access completed with an error |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| eng_start | output | 1 | One-cycle launch of the engine |
| eng_din | output | 128 | Block handed to the engine |
| eng_done | input | 1 | Engine result valid |
| eng_result | input | 128 | Engine result |
| xfer_done | output | 1 | Transfer complete pulse |
| xfer_err | output | 1 | Transfer aborted pulse |

## Verification
Two events can land in the same cycle: the acknowledge of the very last write, which would finish the transfer, and an error answer, which aborts it. The bench provokes this by making its memory model raise `mem_ack` and `mem_err` together on the final write of a two-block transfer. It expects an error pulse, no completion pulse and no request after that access. The same check is repeated with a lone error in the middle of the read phase, and a start strobe that arrives while a transfer is running is judged by the scoreboard still seeing the original addresses and block count.

// File: rtl/blkdma_pkg.sv
// Shared types for the multi-block transfer sequencer.
// Assumes: nothing beyond the users importing this package.
package blkdma_pkg;

    // Sequencer phases: idle, fetching words, launching the engine,
    // waiting for the engine, storing words.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_KICK,
        SQ_WAIT,
        SQ_WRITE
    } sq_state_e;

endpackage

// File: rtl/blkdma_ptr.sv
// Address pointer: loads a start address and moves forward by a fixed
// step for each completed access.
// Assumes: load and adv are not both high; when they are, load wins.
module blkdma_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Pointer register: start address on load, step on each access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= base;
        else if (adv)
            ptr <= ptr + STEP_V;
    end
endmodule

// File: rtl/blkdma_blkcnt.sv
// Remaining-block counter. It is loaded with (blocks - 1), which is the
// upper slice of the size field, and counts down at the end of each block.
// Assumes: dec is only raised while a transfer is running.
module blkdma_blkcnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain_q;

    // Count register: loaded at start, one less per finished block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (dec && (remain_q != '0))
            remain_q <= remain_q - 1'b1;
    end

    assign last = (remain_q == '0);
endmodule

// File: rtl/blkdma_pack.sv
// Word/block converter. Read words are gathered into lanes, lane 0 being
// the most significant word. The engine result is held and handed out
// word by word for the writes, the most significant word first.
// Assumes: WORDS is a power of two and IDX_W = log2(WORDS).
module blkdma_pack #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int IDX_W  = 2,
    parameter int BLK_W  = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              res_load,
    input  logic [BLK_W-1:0]  res_in,
    output logic [BLK_W-1:0]  blk_out,
    output logic [DATA_W-1:0] wr_word
);
    logic [BLK_W-1:0]  res_q;
    logic [DATA_W-1:0] res_lane [WORDS];

    // Result register: holds the engine output during the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (res_load)
            res_q <= res_in;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        logic [DATA_W-1:0] in_q;

        // Input lane: takes the read word whose index matches this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_q <= '0;
            else if (cap_en && (idx == IDX_W'(g)))
                in_q <= rd_word;
        end

        assign blk_out[(WORDS-1-g)*DATA_W +: DATA_W] = in_q;
        assign res_lane[g] = res_q[(WORDS-1-g)*DATA_W +: DATA_W];
    end

    assign wr_word = res_lane[idx];
endmodule

// File: rtl/blkdma_seq.sv
// Multi-block transfer sequencer (top). Each block is read word by word,
// passed through an external engine, then written word by word, until
// the block count taken from the size field is used up.
// Assumes: the memory answers each held request with mem_ack or mem_err
// (an error wins); the engine answers each eng_start with one eng_done.
module blkdma_seq
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 128,
    parameter int SIZE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [SIZE_W-1:0] size_field,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              eng_start,
    output logic [BLK_W-1:0]  eng_din,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result,
    output logic              xfer_done,
    output logic              xfer_err
);
    localparam int WORDS     = BLK_W / DATA_W;
    localparam int IDX_W     = $clog2(WORDS);
    localparam int BLK_BYTES = BLK_W / 8;
    localparam int OFS_BITS  = $clog2(BLK_BYTES);
    localparam int CNT_W     = SIZE_W - OFS_BITS;
    localparam int WSTEP     = DATA_W / 8;

    sq_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             word_last, blk_last;
    logic             launch, rd_ok, wr_ok, in_xfer_phase;
    logic [ADDR_W-1:0] rd_ptr, wr_ptr;
    logic             done_q, err_q;
    logic             sz_unused_lo;

    // The low bits of the size field only pick a byte within the last block.
    assign sz_unused_lo = ^size_field[OFS_BITS-1:0];

    assign launch        = (state_q == SQ_IDLE) && start;
    assign in_xfer_phase = (state_q == SQ_READ) || (state_q == SQ_WRITE);
    assign rd_ok         = (state_q == SQ_READ)  && mem_ack && !mem_err;
    assign wr_ok         = (state_q == SQ_WRITE) && mem_ack && !mem_err;
    assign word_last     = (idx_q == IDX_W'(WORDS - 1));

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:  if (start) state_d = SQ_READ;
            SQ_READ: begin
                if (mem_err)
                    state_d = SQ_IDLE;
                else if (mem_ack && word_last)
                    state_d = SQ_KICK;
            end
            SQ_KICK:  state_d = SQ_WAIT;
            SQ_WAIT:  if (eng_done) state_d = SQ_WRITE;
            SQ_WRITE: begin
                if (mem_err)
                    state_d = SQ_IDLE;
                else if (mem_ack && word_last)
                    state_d = blk_last ? SQ_IDLE : SQ_READ;
            end
            default:  state_d = SQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    // Word index within the block: cleared at launch, one step per access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (launch)
            idx_q <= '0;
        else if (rd_ok || wr_ok)
            idx_q <= idx_q + 1'b1;
    end

    // Completion and abort pulses, each one cycle long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= wr_ok && word_last && blk_last;
            err_q  <= in_xfer_phase && mem_err;
        end
    end

    blkdma_ptr #(.ADDR_W(ADDR_W), .STEP(WSTEP)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .base  (rd_base),
        .adv   (rd_ok),
        .ptr   (rd_ptr)
    );

    blkdma_ptr #(.ADDR_W(ADDR_W), .STEP(WSTEP)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .base  (wr_base),
        .adv   (wr_ok),
        .ptr   (wr_ptr)
    );

    blkdma_blkcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (size_field[SIZE_W-1:OFS_BITS]),
        .dec      (wr_ok && word_last),
        .last     (blk_last)
    );

    blkdma_pack #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (rd_ok),
        .idx      (idx_q),
        .rd_word  (mem_rdata),
        .res_load ((state_q == SQ_WAIT) && eng_done),
        .res_in   (eng_result),
        .blk_out  (eng_din),
        .wr_word  (mem_wdata)
    );

    assign busy      = (state_q != SQ_IDLE);
    assign mem_req   = in_xfer_phase;
    assign mem_we    = (state_q == SQ_WRITE);
    assign mem_addr  = mem_we ? wr_ptr : rd_ptr;
    assign eng_start = (state_q == SQ_KICK);
    assign xfer_done = done_q;
    assign xfer_err  = err_q;
endmodule

// File: rtl/blkdma_seq_chk.sv
// Property checker for the transfer sequencer, attached by bind.
// Assumes: it sees only the ports of blkdma_seq.
module blkdma_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              eng_start,
    input logic              eng_done,
    input logic              xfer_done,
    input logic              xfer_err
);
    // R3
    start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (mem_req && !mem_we));

    // R5
    kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req && !eng_start && !eng_done) |=> !mem_req);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!busy && !mem_req));

    // R9
    err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (xfer_err && !busy && !xfer_done));

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> !xfer_done);
endmodule

bind blkdma_seq blkdma_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err)
);

// File: tb/sim_blkdma_seq.sv
`timescale 1ns/1ps
module sim_blkdma_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  rd_base = '0;
    logic [31:0]  wr_base = '0;
    logic [14:0]  size_field = '0;
    logic         busy, mem_req, mem_we, eng_start, xfer_done, xfer_err;
    logic [31:0]  mem_addr, mem_wdata;
    logic         mem_ack = 1'b0;
    logic         mem_err = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic [127:0] eng_din;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    // Scoreboard queues, filled by the driver and drained by the monitor.
    logic [31:0]  rdq [$];
    logic [127:0] engq [$];
    logic [63:0]  wrq [$];

    // Monitor-owned counters and flags.
    int  acc_num = 0;
    int  eng_starts = 0;
    int  done_cnt = 0;
    int  err_cnt = 0;
    int  wait_cnt = 0;
    int  lat_ptr = 0;
    int  eng_cnt = 0;
    bit  prev_wait = 0;
    bit  prev_kick = 0;
    logic [31:0]  prev_addr = '0;
    logic [31:0]  prev_wdata = '0;
    logic         prev_we = 1'b0;
    logic [127:0] eng_pend = '0;

    // Driver-owned controls.
    bit sb_on = 1;
    int err_at = -1;
    bit err_with_ack = 0;

    always #2 clk = ~clk;

    blkdma_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_base(rd_base),
        .wr_base(wr_base), .size_field(size_field), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_din(eng_din),
        .eng_done(eng_done), .eng_result(eng_result),
        .xfer_done(xfer_done), .xfer_err(xfer_err)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [127:0] eng_fn(input logic [127:0] d);
        return {d[95:0], d[127:96]} ^ {4{32'hC3C3_1234}};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Memory, engine model and monitor, all acting at the falling edge.
    always @(negedge clk) begin
        logic [31:0]  ea;
        logic [63:0]  ew;
        logic [127:0] eb;
        bit responded;
        mem_ack   = 1'b0;
        mem_err   = 1'b0;
        eng_done  = 1'b0;
        responded = 0;
        if (rst_n && mem_req) begin
            if (prev_wait) begin
                // R7: a request not yet answered must stay put.
                chk(mem_addr == prev_addr, "R7", "held address", mem_addr, prev_addr);
                chk(mem_we == prev_we, "R7", "held direction", mem_we, prev_we);
                if (mem_we)
                    chk(mem_wdata == prev_wdata, "R7", "held data", mem_wdata, prev_wdata);
            end
            if (wait_cnt == 0) begin
                responded = 1;
                if (acc_num == err_at) begin
                    mem_err = 1'b1;
                    mem_ack = err_with_ack;
                end else begin
                    mem_ack = 1'b1;
                end
                mem_rdata = mem_word(mem_addr);
                if (sb_on && !mem_err) begin
                    if (!mem_we) begin
                        ea = (rdq.size() > 0) ? rdq.pop_front() : 32'hFFFF_FFFF;
                        // R3: read address sequence.
                        chk(mem_addr == ea, "R3", "read address", mem_addr, ea);
                    end else begin
                        ew = (wrq.size() > 0) ? wrq.pop_front() : 64'hFFFF_FFFF_FFFF_FFFF;
                        // R6: write address and data sequence.
                        chk(mem_addr == ew[63:32], "R6", "write address", mem_addr, ew[63:32]);
                        chk(mem_wdata == ew[31:0], "R6", "write data", mem_wdata, ew[31:0]);
                    end
                end
                acc_num++;
                lat_ptr++;
                wait_cnt = lat_ptr % 3;
            end else begin
                wait_cnt--;
            end
            prev_wait  = !responded;
            prev_addr  = mem_addr;
            prev_we    = mem_we;
            prev_wdata = mem_wdata;
        end else begin
            prev_wait = 0;
        end

        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done   = 1'b1;
                eng_result = eng_pend;
            end
        end
        if (rst_n && eng_start) begin
            // R5: the launch lasts one cycle.
            chk(!prev_kick, "R5", "single-cycle launch", {127'd0, prev_kick}, 128'd0);
            if (sb_on) begin
                eb = (engq.size() > 0) ? engq.pop_front() : '1;
                // R4: block assembled in address order.
                chk(eng_din == eb, "R4", "engine input", eng_din, eb);
            end
            eng_pend = eng_fn(eng_din);
            eng_cnt  = 3;
            eng_starts++;
        end
        prev_kick = eng_start;

        if (rst_n && xfer_done) begin
            done_cnt++;
            // R8: completion shows with the sequencer already idle.
            chk(!busy, "R8", "idle at completion", {127'd0, busy}, 128'd0);
        end
        if (rst_n && xfer_err) err_cnt++;
    end

    task automatic wait_idle();
        for (int i = 0; i < 150000 && busy; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [31:0] rb, input logic [31:0] wb,
                               input logic [14:0] sz);
        @(negedge clk);
        rd_base = rb; wr_base = wb; size_field = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Driver: queue the expected traffic, run one transfer, check the totals.
    task automatic run_xfer(input logic [31:0] rb, input logic [31:0] wb,
                            input logic [14:0] sz, input bit poke_busy);
        int nb;
        int s0, d0, e0;
        logic [127:0] blk, res;
        nb = int'(sz[14:4]) + 1;
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 4; k++) begin
                rdq.push_back(rb + 32'(16*b + 4*k));
                blk[127-32*k -: 32] = mem_word(rb + 32'(16*b + 4*k));
            end
            engq.push_back(blk);
            res = eng_fn(blk);
            for (int k = 0; k < 4; k++)
                wrq.push_back({wb + 32'(16*b + 4*k), res[127-32*k -: 32]});
        end
        s0 = eng_starts; d0 = done_cnt; e0 = err_cnt;
        pulse_start(rb, wb, sz);
        if (poke_busy) begin
            repeat (6) @(negedge clk);
            // R10: a strobe during a run carries other addresses and size.
            pulse_start(32'hDEAD_0000, 32'hBEEF_0000, 15'h7FFF);
        end
        wait_idle();
        repeat (3) @(negedge clk);
        // R2: block count from the upper size bits.
        chk(eng_starts - s0 == nb, "R2", "blocks processed", 128'(eng_starts - s0), 128'(nb));
        chk(rdq.size() == 0, "R3", "reads left over", 128'(rdq.size()), 128'd0);
        chk(wrq.size() == 0, "R6", "writes left over", 128'(wrq.size()), 128'd0);
        // R8: exactly one completion pulse.
        chk(done_cnt - d0 == 1, "R8", "completion pulses", 128'(done_cnt - d0), 128'd1);
        chk(err_cnt == e0, "R9", "no error on clean run", 128'(err_cnt - e0), 128'd0);
        if (poke_busy)
            chk(!busy, "R10", "no second transfer", {127'd0, busy}, 128'd0);
        rdq.delete(); engq.delete(); wrq.delete();
    endtask

    // Error injection on the access with the given index in the run.
    task automatic run_err(input logic [14:0] sz, input int at, input bit with_ack);
        int a0, d0, e0;
        sb_on = 0;
        a0 = acc_num; d0 = done_cnt; e0 = err_cnt;
        err_at = a0 + at;
        err_with_ack = with_ack;
        pulse_start(32'h0000_4000, 32'h0000_8000, sz);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(err_cnt - e0 == 1, "R9", "error pulses", 128'(err_cnt - e0), 128'd1);
        chk(done_cnt == d0, "R9", "no completion after error", 128'(done_cnt - d0), 128'd0);
        chk(acc_num - a0 == at + 1, "R9", "accesses until abort", 128'(acc_num - a0), 128'(at + 1));
        chk(!busy && !mem_req, "R9", "idle after abort", {126'd0, busy, mem_req}, 128'd0);
        err_at = -1;
        sb_on = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk({busy, mem_req, eng_start, xfer_done, xfer_err} == 5'b0, "R1", "reset outputs",
            128'({busy, mem_req, eng_start, xfer_done, xfer_err}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, mem_req, eng_start, xfer_done, xfer_err} == 5'b0, "R1", "idle after reset",
            128'({busy, mem_req, eng_start, xfer_done, xfer_err}), 128'd0);

        run_xfer(32'h0000_1000, 32'h0000_2000, 15'h000F, 0); // R2 one block
        run_xfer(32'h0001_0000, 32'h0002_0000, 15'h001F, 0); // R2 two blocks
        run_xfer(32'h0003_0040, 32'h0004_0080, 15'h0015, 0); // R2 low bits ignored
        run_xfer(32'h0005_0000, 32'h0006_0000, 15'h0000, 0); // R2 zero field
        run_xfer(32'h0007_0000, 32'h0008_0000, 15'h004F, 1); // R10 start while busy
        run_err(15'h001F, 2, 0);   // R9 error in read phase
        run_err(15'h001F, 15, 1);  // R9 error together with ack on the last write
        run_xfer(32'h0009_0000, 32'h000A_0000, 15'h002F, 0); // recovery after abort
        run_xfer(32'h0010_0000, 32'h0020_0000, 15'h7FFF, 0); // R2 largest transfer

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule